// File: doc/BRIEF.md
# One-Hot Fuse Blow and Readback Controller

This controller owns a small bank of one-time fuse cells arranged as several registers of nine bits each. The cells are modelled as sticky flip-flops that only a separate bank-initialisation reset clears. A front end, outside this block, decodes the programming pulse train and hands over qualified single-cycle events: the end of parameter selection, each mid-level pulse falling edge, and each qualified blow pulse. It also holds the mode levels and the selected register number.

In blow mode the controller keeps a one-hot pointer into the selected register. The pointer starts at bit 0, and each mid pulse moves it one place left. A blow pulse fires a single-cycle strobe that sets exactly one cell. After any blow the controller halts until the next power cycle. Locking takes two steps. The lock-all cell is blown first. The next accepted blow then sets an internal final-lock cell instead of the addressed bit, and after that every blow is refused. In read mode the cells of the selected register are presented one per event, least significant bit first, as a 2-bit step code.

Top module: `fuse_blow_ctrl`

## Requirements
- R1: When selection ends with blow mode active, the pointer addresses bit 0. Each mid pulse falling edge moves it to the next higher bit, so n pulses address bit n. The pointer stays at bit 8 once it gets there.
- R2: A blow pulse in blow addressing raises `blow_stb` for exactly one cycle, beginning the cycle after the pulse. At the same time `blow_mask` shows the addressed bit as a one-hot value (bit i means cell i), and only that cell of the selected register becomes set. Whenever `blow_stb` is low, `blow_mask` is zero.
- R3: After a blow pulse, further selection ends, mid pulses and blow pulses have no effect until `pwr_rst_n` is asserted. At most one strobe occurs per power cycle.
- R4: Blown cells survive `pwr_rst_n` and accumulate, so later blows add bits to the same register. Only `fuse_init_n` clears them.
- R5: Register select value 3 is the lock register. Its cells at bits 0 to 2 (margin) and bit 8 (lock-all) are blown like any other cell.
- R6: Once the lock-all cell is set, the next blow gives a strobe with `blow_mask` equal to 0 and raises `final_locked`, and the addressed cell stays unblown. After that, `final_locked` stays high and no blow pulse gives a strobe.
- R7: When selection ends with read mode active (and blow mode inactive), bit 0 of the selected register is presented. Each mid pulse falling edge presents the next bit. Read mode works after final lock.
- R8: `rd_level` is 01 while read mode is requested and no sequence has started. While bits are streaming it is 10 for a blown cell and 00 for an unblown cell. It is 00 in all other cases, and the code 11 never appears.
- R9: After bit 8 has been presented, further mid pulses hold `rd_level` at 00. A freshly initialised bank reads as all zeros.
- R10: Before any sequence has started, blow pulses and mid pulses give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Active-low power-cycle reset of the sequencing state |
| fuse_init_n | input | 1 | Active-low initialisation of the fuse cells and final-lock cell |
| mode_blow | input | 1 | Blow/lock mode is selected |
| mode_read | input | 1 | Read mode is selected |
| reg_sel | input | 2 | Selected register (0 to 3; 3 is the lock register) |
| sel_end_fall | input | 1 | Falling edge of the high pulse that ends parameter selection |
| mid_fall | input | 1 | Falling edge of a mid-level pulse |
| blow_pulse | input | 1 | Qualified blow pulse |
| blow_stb | output | 1 | Single-cycle fuse blow strobe |
| blow_mask | output | 9 | One-hot cell being blown; zero for the final-lock cell |
| final_locked | output | 1 | Final-lock cell is set |
| rd_level | output | 2 | Readback step code: 00 none, 01 one step, 10 two steps |

## Verification
The checker watches several properties on every cycle. The strobe mask must be one-hot or zero. No second strobe may appear within a power cycle, and every strobe must follow a blow pulse. Final lock must be sticky, no strobe may follow it, and the level code must never be 11. Some behaviour only the bench scenarios can show. These are the pointer position reached after a given number of mid pulses, and which cell ends up set in which register. They also cover the accumulation of bits across power cycles, the two-step lock that leaves the addressed bit untouched, and the serial order and encoding of the readback. The bench sweeps pulse counts over every register and reads each register back after each blow.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_HALT = 2'd2,
        ST_READ = 2'd3
    } fc_state_e;

    localparam logic [1:0] LVL_NONE = 2'b00;
    localparam logic [1:0] LVL_ONE  = 2'b01;
    localparam logic [1:0] LVL_TWO  = 2'b10;
endpackage

// File: rtl/fc_onehot_ptr.sv
module fc_onehot_ptr #(
    parameter int NBITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    output logic [NBITS-1:0] ptr
);
    logic [NBITS-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load) begin
            ptr_d = {{(NBITS-1){1'b0}}, 1'b1};
        end else if (shift && !ptr_q[NBITS-1]) begin
            ptr_d = ptr_q << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/fc_fuse_bank.sv
module fc_fuse_bank #(
    parameter int NREGS = 4,
    parameter int NBITS = 9,
    localparam int REGW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic                   clk,
    input  logic                   init_n,
    input  logic                   set_en,
    input  logic [REGW-1:0]        set_reg,
    input  logic [NBITS-1:0]       set_mask,
    input  logic                   lock_en,
    output logic [NREGS*NBITS-1:0] cells,
    output logic                   final_lock
);
    logic [NBITS-1:0] fuse_d [NREGS];
    logic [NBITS-1:0] fuse_q [NREGS];
    logic             flock_d, flock_q;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_comb begin
            fuse_d[g] = fuse_q[g];
            if (set_en && (set_reg == REGW'(g))) fuse_d[g] = fuse_q[g] | set_mask;
        end

        always_ff @(posedge clk or negedge init_n) begin
            if (!init_n) fuse_q[g] <= '0;
            else         fuse_q[g] <= fuse_d[g];
        end

        assign cells[g*NBITS +: NBITS] = fuse_q[g];
    end

    always_comb flock_d = flock_q | lock_en;

    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) flock_q <= 1'b0;
        else         flock_q <= flock_d;
    end

    assign final_lock = flock_q;
endmodule

// File: rtl/fc_read_encoder.sv
module fc_read_encoder #(
    parameter int NBITS = 9,
    localparam int IDXW = $clog2(NBITS + 1)
) (
    input  logic             armed,
    input  logic             streaming,
    input  logic [IDXW-1:0]  idx,
    input  logic [NBITS-1:0] word,
    output logic [1:0]       level
);
    import fusectl_pkg::*;

    always_comb begin
        level = LVL_NONE;
        if (armed) begin
            level = LVL_ONE;
        end else if (streaming && (idx < IDXW'(NBITS))) begin
            level = word[idx] ? LVL_TWO : LVL_NONE;
        end
    end
endmodule

// File: rtl/fuse_blow_ctrl.sv
module fuse_blow_ctrl #(
    parameter int NREGS    = 4,
    parameter int NBITS    = 9,
    parameter int LOCK_REG = 3,
    parameter int LOCK_BIT = 8,
    localparam int REGW    = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int IDXW    = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             pwr_rst_n,
    input  logic             fuse_init_n,
    input  logic             mode_blow,
    input  logic             mode_read,
    input  logic [REGW-1:0]  reg_sel,
    input  logic             sel_end_fall,
    input  logic             mid_fall,
    input  logic             blow_pulse,
    output logic             blow_stb,
    output logic [NBITS-1:0] blow_mask,
    output logic             final_locked,
    output logic [1:0]       rd_level
);
    import fusectl_pkg::*;

    localparam int LOCK_IDX = LOCK_REG * NBITS + LOCK_BIT;

    typedef struct packed {
        fc_state_e        st;
        logic [REGW-1:0]  rsel;
        logic [IDXW-1:0]  idx;
        logic             stb;
        logic [NBITS-1:0] mask;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic                   ptr_load, ptr_shift;
    logic [NBITS-1:0]       ptr;
    logic                   set_en, lock_en;
    logic [NREGS*NBITS-1:0] cells;
    logic                   flock;

    fc_onehot_ptr #(.NBITS(NBITS)) u_ptr (
        .clk   (clk),
        .rst_n (pwr_rst_n),
        .load  (ptr_load),
        .shift (ptr_shift),
        .ptr   (ptr)
    );

    fc_fuse_bank #(.NREGS(NREGS), .NBITS(NBITS)) u_bank (
        .clk        (clk),
        .init_n     (fuse_init_n),
        .set_en     (set_en),
        .set_reg    (cur_q.rsel),
        .set_mask   (ptr),
        .lock_en    (lock_en),
        .cells      (cells),
        .final_lock (flock)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.stb = 1'b0;
        nxt_d.mask = '0;
        ptr_load  = 1'b0;
        ptr_shift = 1'b0;
        set_en    = 1'b0;
        lock_en   = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (sel_end_fall) begin
                    if (mode_blow) begin
                        nxt_d.st   = ST_ADDR;
                        nxt_d.rsel = reg_sel;
                        ptr_load   = 1'b1;
                    end else if (mode_read) begin
                        nxt_d.st   = ST_READ;
                        nxt_d.rsel = reg_sel;
                        nxt_d.idx  = '0;
                    end
                end
            end
            ST_ADDR: begin
                if (blow_pulse) begin
                    nxt_d.st = ST_HALT;
                    if (!flock) begin
                        nxt_d.stb = 1'b1;
                        if (cells[LOCK_IDX]) begin
                            lock_en = 1'b1;
                        end else begin
                            set_en     = 1'b1;
                            nxt_d.mask = ptr;
                        end
                    end
                end else if (mid_fall) begin
                    ptr_shift = 1'b1;
                end
            end
            ST_READ: begin
                if (mid_fall && (cur_q.idx != IDXW'(NBITS))) nxt_d.idx = cur_q.idx + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.rsel <= '0;
            cur_q.idx  <= '0;
            cur_q.stb  <= 1'b0;
            cur_q.mask <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    fc_read_encoder #(.NBITS(NBITS)) u_enc (
        .armed     ((cur_q.st == ST_IDLE) && mode_read && !mode_blow),
        .streaming (cur_q.st == ST_READ),
        .idx       (cur_q.idx),
        .word      (cells[cur_q.rsel*NBITS +: NBITS]),
        .level     (rd_level)
    );

    assign blow_stb     = cur_q.stb;
    assign blow_mask    = cur_q.mask;
    assign final_locked = flock;
endmodule

// File: rtl/fuse_blow_ctrl_checker.sv
module fuse_blow_ctrl_checker #(
    parameter int NBITS = 9
) (
    input logic             clk,
    input logic             pwr_rst_n,
    input logic             fuse_init_n,
    input logic             blow_pulse,
    input logic             blow_stb,
    input logic [NBITS-1:0] blow_mask,
    input logic             final_locked,
    input logic [1:0]       rd_level
);
    logic seen_q;

    always_ff @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n)    seen_q <= 1'b0;
        else if (blow_stb) seen_q <= 1'b1;
    end

    p_mask_onehot_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        blow_stb |-> $onehot0(blow_mask));

    p_mask_quiet_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        !blow_stb |-> (blow_mask == '0));

    p_stb_after_pulse_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        blow_stb |-> $past(blow_pulse));

    p_single_blow_r3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        seen_q |-> !blow_stb);

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!fuse_init_n)
        final_locked |=> final_locked);

    p_lock_fuse_r6: assert property (@(posedge clk) disable iff (!pwr_rst_n || !fuse_init_n)
        (blow_stb && (blow_mask == '0)) |-> final_locked);

    p_locked_no_stb_r6: assert property (@(posedge clk) disable iff (!pwr_rst_n || !fuse_init_n)
        $past(final_locked) |-> !blow_stb);

    p_level_legal_r8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        rd_level != 2'b11);
endmodule

bind fuse_blow_ctrl fuse_blow_ctrl_checker #(.NBITS(NBITS)) u_chk (
    .clk          (clk),
    .pwr_rst_n    (pwr_rst_n),
    .fuse_init_n  (fuse_init_n),
    .blow_pulse   (blow_pulse),
    .blow_stb     (blow_stb),
    .blow_mask    (blow_mask),
    .final_locked (final_locked),
    .rd_level     (rd_level)
);

// File: tb/fuse_blow_ctrl_tb.sv
`timescale 1ns/1ps
module fuse_blow_ctrl_tb;
    logic       clk = 1'b0;
    logic       pwr_rst_n = 1'b0;
    logic       fuse_init_n = 1'b0;
    logic       mode_blow = 1'b0;
    logic       mode_read = 1'b0;
    logic [1:0] reg_sel = '0;
    logic       sel_end_fall = 1'b0;
    logic       mid_fall = 1'b0;
    logic       blow_pulse = 1'b0;
    logic       blow_stb;
    logic [8:0] blow_mask;
    logic       final_locked;
    logic [1:0] rd_level;

    int checks = 0;
    int fails = 0;
    logic [8:0] model [4];

    always #10 clk = ~clk;

    fuse_blow_ctrl u_dut (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .fuse_init_n(fuse_init_n),
        .mode_blow(mode_blow), .mode_read(mode_read), .reg_sel(reg_sel),
        .sel_end_fall(sel_end_fall), .mid_fall(mid_fall), .blow_pulse(blow_pulse),
        .blow_stb(blow_stb), .blow_mask(blow_mask), .final_locked(final_locked),
        .rd_level(rd_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_sel();
        @(negedge clk) sel_end_fall = 1'b1;
        @(negedge clk) sel_end_fall = 1'b0;
    endtask

    task automatic pulse_mid();
        @(negedge clk) mid_fall = 1'b1;
        @(negedge clk) mid_fall = 1'b0;
    endtask

    task automatic pulse_blow();
        @(negedge clk) blow_pulse = 1'b1;
        @(negedge clk) blow_pulse = 1'b0;
    endtask

    task automatic power_cycle();
        @(negedge clk) pwr_rst_n = 1'b0;
        @(negedge clk) pwr_rst_n = 1'b1;
    endtask

    // R7 R8 R9: serial readback of one register
    task automatic do_read(input int r);
        power_cycle();
        mode_read = 1'b1;
        reg_sel = 2'(r);
        @(negedge clk);
        chk("R8 armed level", rd_level, 1);
        pulse_sel();
        for (int b = 0; b < 9; b++) begin
            chk("R7 bit level", rd_level, model[r][b] ? 2 : 0);
            pulse_mid();
        end
        chk("R9 past end", rd_level, 0);
        pulse_mid();
        chk("R9 past end held", rd_level, 0);
        mode_read = 1'b0;
    endtask

    // R1 R2: address bit via n mid pulses and blow it
    task automatic do_blow(input int r, input int n, input int exp_stb, input int exp_mask);
        power_cycle();
        mode_blow = 1'b1;
        reg_sel = 2'(r);
        pulse_sel();
        mode_blow = 1'b0;
        for (int i = 0; i < n; i++) pulse_mid();
        pulse_blow();
        chk("R2 strobe", blow_stb, exp_stb);
        chk("R1 mask", blow_mask, exp_mask);
        @(negedge clk);
        chk("R2 strobe one cycle", blow_stb, 0);
        chk("R2 mask cleared", blow_mask, 0);
    endtask

    initial begin
        for (int r = 0; r < 4; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        fuse_init_n = 1'b1;
        pwr_rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset level", rd_level, 0);
        chk("R2 reset strobe", blow_stb, 0);
        chk("R6 reset lock", final_locked, 0);

        // R10: idle ignores blow and mid pulses
        pulse_mid();
        pulse_blow();
        chk("R10 idle blow", blow_stb, 0);
        @(negedge clk);
        chk("R10 idle blow late", blow_stb, 0);

        // R9: fresh bank reads zero
        for (int r = 0; r < 4; r++) do_read(r);

        // R1 R2 R4 R5: sweep pulse counts over all registers
        for (int r = 0; r < 4; r++) begin
            for (int n = 0; n < 9; n++) begin
                if (!(r == 3 && n == 8) && ((r * 5 + n) % 3 == 0)) begin
                    do_blow(r, n, 1, 1 << n);
                    model[r][n] = 1'b1;
                    do_read(r);
                end
            end
        end

        // R1: saturation at bit 8
        do_blow(0, 12, 1, 1 << 8);
        model[0][8] = 1'b1;

        // R3: everything ignored after a blow until power cycle
        do_blow(1, 2, 1, 1 << 2);
        model[1][2] = 1'b1;
        mode_blow = 1'b1;
        pulse_sel();
        mode_blow = 1'b0;
        pulse_mid();
        pulse_blow();
        chk("R3 second blow", blow_stb, 0);
        @(negedge clk);
        chk("R3 second blow late", blow_stb, 0);
        do_read(1);
        do_read(0);

        // R5: margin bits in lock register
        do_blow(3, 1, 1, 1 << 1);
        model[3][1] = 1'b1;
        do_read(3);

        // R5 R6: lock-all bit, then final lock
        do_blow(3, 8, 1, 1 << 8);
        model[3][8] = 1'b1;
        chk("R6 not yet final", final_locked, 0);
        do_read(3);
        do_blow(0, 1, 1, 0);
        chk("R6 final lock set", final_locked, 1);
        do_read(0);
        do_blow(2, 4, 0, 0);
        chk("R6 lock held", final_locked, 1);

        // R4 R7: all registers still readable after lock
        for (int r = 0; r < 4; r++) do_read(r);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule